// File: doc/BRIEF.md
# Reorder Buffer with Throttled Squash

This block keeps in-flight instruction records in program order inside a circular buffer. Each slot holds a program counter, the following program counter, a 32-bit sequence number, a commit-ready flag and a squashed flag. The front end allocates records at the tail. The commit stage retires the head record once that record is ready. Execution units mark a record ready by writing its slot index, which they learn from the tail index at allocation time.

A squash request names a sequence number. The block then walks backward from the tail and marks every younger record both squashed and ready. Squashed records are not discarded. They drain through normal retirement, and the commit stage can see from the head-squashed flag that their results must be dropped. The walk handles at most `SQ_W` records per cycle. It ends at the record that carries the named sequence number, or at the head if no record carries it.

Top module: `rob_squash_buffer`

## Requirements
- R1: After reset the occupancy is 0, the free count equals `DEPTH`, head-ready is low and squash-done is high.
- R2: An accepted insertion raises the occupancy by one and makes the new record the tail. On an empty buffer, the new record is both head and tail.
- R3: An insertion while the occupancy equals `DEPTH` is rejected, leaves the contents unchanged and raises `ins_full_err` in the same cycle.
- R4: `free_cnt` always equals `DEPTH` minus the occupancy.
- R5: A retire strobe removes only the head record, and only when that record is ready. Otherwise it is ignored. Records retire in insertion order.
- R6: `head_ready` is low whenever the buffer is empty.
- R7: Asserting `mark_valid` with slot index `mark_slot` sets the commit-ready flag of that slot one cycle later.
- R8: A squash request on a non-empty, idle buffer drops `sq_done` on the next edge. A squash request on an empty buffer is ignored.
- R9: Each cycle of the walk marks at most `SQ_W` records squashed and ready. It moves from the tail toward the head, and every record it marks is younger than the squash number.
- R10: The walk stops at the record whose sequence number equals the squash number and leaves that record and all older records untouched. `sq_done` rises on the edge where the match is found, or where it is seen just past the last record marked that cycle.
- R11: If the walk marks the head record without finding the squash number, it ends on that edge and `sq_done` rises.
- R12: While a squash is in progress, insertions and further squash requests are ignored. Retirement continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert a record at the tail |
| ins_pc | input | PC_W | PC of the inserted record |
| ins_npc | input | PC_W | Next PC of the inserted record |
| ins_seq | input | SEQ_W | Sequence number of the inserted record |
| ins_full_err | output | 1 | Insertion attempted while full |
| ret_strobe | input | 1 | Retire the head record if it is ready |
| mark_valid | input | 1 | Mark a slot ready to commit |
| mark_slot | input | PTR_W | Slot index to mark |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash sequence number |
| sq_done | output | 1 | High when no squash walk is running |
| occupancy | output | CNT_W | Records held |
| free_cnt | output | CNT_W | Free slots |
| head_ready | output | 1 | Head record is ready to commit |
| head_squashed | output | 1 | Head record was squashed |
| head_idx | output | PTR_W | Slot index of the head |
| tail_idx | output | PTR_W | Slot index of the tail |
| head_pc | output | PC_W | PC of the head record |
| head_npc | output | PC_W | Next PC of the head record |
| head_seq | output | SEQ_W | Sequence number of the head record |
| tail_pc | output | PC_W | PC of the tail record |
| tail_seq | output | SEQ_W | Sequence number of the tail record |

## Verification
The embedded properties check these rules on every cycle:
- the occupancy bound,
- head-ready staying low when the buffer is empty,
- rejection of inserts when full or while a squash runs,
- ignored retires of a record that is not ready,
- the per-cycle limit on marks,
- every marked record being younger than the squash number,
- no marks while the walker is idle.

Only the directed scenarios can show where the walk stops and when it finishes. They cover a stop at a matching record, a stop at the head, and an immediate match at the tail. The scenarios also show which records come out squashed during the drain, the FIFO retirement order, and pointer wrap-around.

// File: rtl/rob_pkg.sv
package rob_pkg;
    parameter int PC_W  = 32;
    parameter int SEQ_W = 32;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  npc;
        logic [SEQ_W-1:0] seq;
    } rob_rec_t;

    typedef struct packed {
        rob_rec_t rec;
        logic     rdy;
        logic     sq;
    } rob_ent_t;
endpackage

// File: rtl/rob_entry_store.sv
module rob_entry_store
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PTR_W-1:0]            wr_slot,
    input  rob_rec_t                    wr_rec,
    input  logic                        rdy_en,
    input  logic [PTR_W-1:0]            rdy_slot,
    input  logic [DEPTH-1:0]            sq_mask,
    output rob_ent_t [DEPTH-1:0]        ents_o
);
    rob_ent_t [DEPTH-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (sq_mask[i]) begin
                ent_d[i].sq  = 1'b1;
                ent_d[i].rdy = 1'b1;
            end
        end
        if (rdy_en) ent_d[rdy_slot].rdy = 1'b1;
        if (wr_en) begin
            ent_d[wr_slot].rec = wr_rec;
            ent_d[wr_slot].rdy = 1'b0;
            ent_d[wr_slot].sq  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign ents_o = ent_q;

    // R7: a marked slot reads ready on the following cycle unless overwritten
    assert_mark_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_en && !(wr_en && wr_slot == rdy_slot)) |=> ents_o[$past(rdy_slot)].rdy);
endmodule

// File: rtl/rob_squash_walk.sv
module rob_squash_walk
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SQ_W  = 2,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [SEQ_W-1:0]              start_seq,
    input  logic [PTR_W-1:0]              tail_i,
    input  logic [PTR_W-1:0]              head_i,
    input  logic [DEPTH-1:0][SEQ_W-1:0]   seq_i,
    output logic [DEPTH-1:0]              mark_o,
    output logic                          busy_o
);
    typedef struct packed {
        logic             active;
        logic [PTR_W-1:0] cursor;
        logic [SEQ_W-1:0] target;
    } walk_t;

    walk_t w_d, w_q;
    logic [PTR_W-1:0] pos;
    logic             stop;

    function automatic logic [PTR_W-1:0] step_back(input logic [PTR_W-1:0] p, input int k);
        int t;
        t = int'(p) - k;
        if (t < 0) t = t + DEPTH;
        return PTR_W'(t);
    endfunction

    always_comb begin
        w_d    = w_q;
        mark_o = '0;
        stop   = 1'b0;
        pos    = w_q.cursor;
        if (w_q.active) begin
            for (int k = 0; k <= SQ_W; k++) begin
                if (!stop) begin
                    pos = step_back(w_q.cursor, k);
                    if (seq_i[pos] == w_q.target) begin
                        stop = 1'b1;
                    end else if (k < SQ_W) begin
                        mark_o[pos] = 1'b1;
                        if (pos == head_i) stop = 1'b1;
                    end
                end
            end
            if (stop) w_d.active = 1'b0;
            else      w_d.cursor = step_back(w_q.cursor, SQ_W);
        end else if (start) begin
            w_d.active = 1'b1;
            w_d.cursor = tail_i;
            w_d.target = start_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign busy_o = w_q.active;

    assert_mark_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mark_o) <= SQ_W);

    assert_idle_no_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mark_o == '0));

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_younger
            assert_visit_younger_R9: assert property (@(posedge clk) disable iff (!rst_n)
                mark_o[g] |-> (seq_i[g] > w_q.target));
        end
    endgenerate
endmodule

// File: rtl/rob_squash_buffer.sv
module rob_squash_buffer
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SQ_W  = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [PC_W-1:0]  ins_npc,
    input  logic [SEQ_W-1:0] ins_seq,
    output logic             ins_full_err,
    input  logic             ret_strobe,
    input  logic             mark_valid,
    input  logic [PTR_W-1:0] mark_slot,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             sq_done,
    output logic [CNT_W-1:0] occupancy,
    output logic [CNT_W-1:0] free_cnt,
    output logic             head_ready,
    output logic             head_squashed,
    output logic [PTR_W-1:0] head_idx,
    output logic [PTR_W-1:0] tail_idx,
    output logic [PC_W-1:0]  head_pc,
    output logic [PC_W-1:0]  head_npc,
    output logic [SEQ_W-1:0] head_seq,
    output logic [PC_W-1:0]  tail_pc,
    output logic [SEQ_W-1:0] tail_seq
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] count;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    rob_ent_t [DEPTH-1:0]            ents;
    logic [DEPTH-1:0][SEQ_W-1:0]     seqs;
    logic [DEPTH-1:0]                sq_mark;
    logic                            busy;
    logic                            full, empty, do_ins, do_ret, sq_start;
    rob_rec_t                        new_rec;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (ctl_q.count == CNT_W'(DEPTH));
    assign empty    = (ctl_q.count == '0);
    assign do_ins   = ins_valid && !full && !busy;
    assign do_ret   = ret_strobe && !empty && ents[ctl_q.head].rdy;
    assign sq_start = sq_valid && !empty;
    assign new_rec  = '{pc: ins_pc, npc: ins_npc, seq: ins_seq};

    always_comb begin
        ctl_d = ctl_q;
        if (do_ins) ctl_d.wr   = advance(ctl_q.wr);
        if (do_ret) ctl_d.head = advance(ctl_q.head);
        ctl_d.count = ctl_q.count + CNT_W'(do_ins) - CNT_W'(do_ret);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_seq
            assign seqs[g] = ents[g].rec.seq;
        end
    endgenerate

    rob_entry_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_ins),
        .wr_slot  (ctl_q.wr),
        .wr_rec   (new_rec),
        .rdy_en   (mark_valid),
        .rdy_slot (mark_slot),
        .sq_mask  (sq_mark),
        .ents_o   (ents)
    );

    rob_squash_walk #(.DEPTH(DEPTH), .SQ_W(SQ_W), .PTR_W(PTR_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sq_start),
        .start_seq (sq_seq),
        .tail_i    (tail_idx),
        .head_i    (ctl_q.head),
        .seq_i     (seqs),
        .mark_o    (sq_mark),
        .busy_o    (busy)
    );

    assign tail_idx      = (ctl_q.wr == '0) ? PTR_W'(DEPTH - 1) : ctl_q.wr - 1'b1;
    assign head_idx      = ctl_q.head;
    assign ins_full_err  = ins_valid && full;
    assign sq_done       = !busy;
    assign occupancy     = ctl_q.count;
    assign free_cnt      = CNT_W'(DEPTH) - ctl_q.count;
    assign head_ready    = !empty && ents[ctl_q.head].rdy;
    assign head_squashed = ents[ctl_q.head].sq;
    assign head_pc       = ents[ctl_q.head].rec.pc;
    assign head_npc      = ents[ctl_q.head].rec.npc;
    assign head_seq      = ents[ctl_q.head].rec.seq;
    assign tail_pc       = ents[tail_idx].rec.pc;
    assign tail_seq      = ents[tail_idx].rec.seq;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    assert_full_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && occupancy == CNT_W'(DEPTH) && !ret_strobe) |=> occupancy == CNT_W'(DEPTH));

    assert_insert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_full_err && sq_done && !ret_strobe) |=> occupancy == $past(occupancy) + 1'b1);

    assert_retire_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && !head_ready && !ins_valid) |=> $stable(occupancy));

    assert_empty_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0) |-> !head_ready);

    assert_squash_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && sq_done && occupancy != '0) |=> !sq_done);

    assert_busy_no_insert_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sq_done && ins_valid && !ret_strobe) |=> $stable(occupancy));
endmodule

// File: tb/rob_squash_buffer_tb.sv
module rob_squash_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int PTR_W = 3;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 1'b0;
    logic [31:0] ins_pc = '0, ins_npc = '0, ins_seq = '0;
    logic ins_full_err;
    logic ret_strobe = 1'b0;
    logic mark_valid = 1'b0;
    logic [PTR_W-1:0] mark_slot = '0;
    logic sq_valid = 1'b0;
    logic [31:0] sq_seq = '0;
    logic sq_done;
    logic [CNT_W-1:0] occupancy, free_cnt;
    logic head_ready, head_squashed;
    logic [PTR_W-1:0] head_idx, tail_idx;
    logic [31:0] head_pc, head_npc, head_seq, tail_pc, tail_seq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_squash_buffer #(.DEPTH(DEPTH), .SQ_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_npc(ins_npc), .ins_seq(ins_seq),
        .ins_full_err(ins_full_err), .ret_strobe(ret_strobe),
        .mark_valid(mark_valid), .mark_slot(mark_slot),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_done(sq_done),
        .occupancy(occupancy), .free_cnt(free_cnt),
        .head_ready(head_ready), .head_squashed(head_squashed),
        .head_idx(head_idx), .tail_idx(tail_idx),
        .head_pc(head_pc), .head_npc(head_npc), .head_seq(head_seq),
        .tail_pc(tail_pc), .tail_seq(tail_seq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] seq);
        ins_valid = 1'b1; ins_seq = seq;
        ins_pc = 32'h1000 + seq * 4; ins_npc = 32'h1004 + seq * 4;
        step();
        ins_valid = 1'b0;
    endtask

    task automatic mark_head();
        mark_valid = 1'b1; mark_slot = head_idx;
        step();
        mark_valid = 1'b0;
    endtask

    task automatic retire_one();
        ret_strobe = 1'b1;
        step();
        ret_strobe = 1'b0;
    endtask

    task automatic t_reset();
        repeat (2) step();
        rst_n = 1'b1;
        step();
        chk("R1 occupancy", occupancy, 0);
        chk("R1 free", free_cnt, DEPTH);
        chk("R1 head_ready", head_ready, 0);
        chk("R1 sq_done", sq_done, 1);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) begin
            push(100 + i);
            chk("R2 occupancy", occupancy, i + 1);
            chk("R4 free", free_cnt, DEPTH - i - 1);
            chk("R2 tail_seq", tail_seq, 100 + i);
            if (i == 0) begin
                chk("R2 head=tail seq", head_seq, tail_seq);
                chk("R2 head=tail pc", head_pc, 32'h1000 + 400);
                chk("R2 head npc", head_npc, 32'h1004 + 400);
            end
        end
        ins_valid = 1'b1; ins_seq = 999;
        #1;
        chk("R3 full err", ins_full_err, 1);
        step();
        ins_valid = 1'b0;
        chk("R3 occupancy", occupancy, DEPTH);
        chk("R3 tail_seq", tail_seq, 107);
        chk("R4 free full", free_cnt, 0);
    endtask

    task automatic t_retire();
        retire_one();
        chk("R5 not ready ignored", occupancy, DEPTH);
        chk("R5 head kept", head_seq, 100);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R5 order", head_seq, 100 + i);
            mark_head();
            chk("R7 marked ready", head_ready, 1);
            retire_one();
            chk("R5 occupancy", occupancy, DEPTH - 1 - i);
        end
        chk("R6 empty not ready", head_ready, 0);
        chk("R4 free empty", free_cnt, DEPTH);
        sq_valid = 1'b1; sq_seq = 3;
        step();
        sq_valid = 1'b0;
        chk("R8 empty squash ignored", sq_done, 1);
    endtask

    task automatic t_squash_match();
        for (int i = 0; i < 6; i++) push(10 + i);
        mark_head();
        sq_valid = 1'b1; sq_seq = 11;
        step();
        sq_valid = 1'b0;
        chk("R8 done dropped", sq_done, 0);
        ins_valid = 1'b1; ins_seq = 99;
        sq_valid = 1'b1; sq_seq = 13;
        ret_strobe = 1'b1;
        step();
        ins_valid = 1'b0; sq_valid = 1'b0; ret_strobe = 1'b0;
        chk("R12 insert ignored, retire done", occupancy, 5);
        chk("R12 tail kept", tail_seq, 15);
        chk("R9 still walking", sq_done, 0);
        chk("R12 retired head", head_seq, 11);
        step();
        chk("R10 done at match", sq_done, 1);
        mark_head();
        for (int i = 0; i < 5; i++) begin
            chk("R10 drain seq", head_seq, 11 + i);
            chk("R10 squashed flag", head_squashed, (i == 0) ? 0 : 1);
            chk("R9 squashed ready", head_ready, 1);
            retire_one();
        end
        chk("R5 drained", occupancy, 0);
    endtask

    task automatic t_squash_head();
        push(20); push(21); push(22);
        sq_valid = 1'b1; sq_seq = 5;
        step();
        sq_valid = 1'b0;
        chk("R8 done low", sq_done, 0);
        step();
        chk("R9 rate limited", sq_done, 0);
        step();
        chk("R11 done at head", sq_done, 1);
        for (int i = 0; i < 3; i++) begin
            chk("R11 drain seq", head_seq, 20 + i);
            chk("R11 squashed", head_squashed, 1);
            chk("R11 ready", head_ready, 1);
            retire_one();
        end
        chk("R11 drained", occupancy, 0);
    endtask

    task automatic t_squash_tail();
        push(30); push(31);
        sq_valid = 1'b1; sq_seq = 31;
        step();
        sq_valid = 1'b0;
        step();
        chk("R10 tail match done", sq_done, 1);
        chk("R10 older untouched", head_squashed, 0);
        chk("R10 older not ready", head_ready, 0);
        mark_head();
        retire_one();
        chk("R10 match seq", head_seq, 31);
        chk("R10 match untouched", head_squashed, 0);
        chk("R10 match not ready", head_ready, 0);
        mark_head();
        retire_one();
        chk("R6 final empty", head_ready, 0);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_retire();
        t_squash_match();
        t_squash_head();
        t_squash_tail();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule